// File: doc/BRIEF.md
# Glitch-Free Five-Source Clock Selector

This block picks one of five free-running input clocks and passes it to a single clock output for a clock domain. The handover never produces a runt pulse. Software writes a 3-bit source code through a small register-style port. Codes 0 to 4 stand for, in order: the slow real-time clock, the main oscillator, and three synthesiser outputs. The block then runs a handshake. First it removes the clock currently in use, acting in that clock's own domain on a falling edge. Only when that removal has been confirmed back in the control domain does it engage the new clock, again on a falling edge in the new clock's own domain. A busy flag stays high until the new source is confirmed to be driving the output.

The control word holds two fields. The select field is `wdata[2:0]` and `rdata[2:0]`. A spare control field, handed to later stages, is `wdata[7:3]` and `rdata[7:3]`. Each field has its own write strobe, so a select write never disturbs the spare bits. Invalid codes, writes issued while a handover is running, and any select write to a pinned instance are all refused, and each of them raises a sticky error flag. The `PINNED` parameter fixes an instance permanently on the source given by `PINNED_CODE` (4 by default).

Top module: `clk_src_switch`

## Requirements
- R1: While `rst` is high, `rdata[2:0]` reads 1, or `PINNED_CODE` on a pinned instance, and `err` and `rdata[7:3]` read 0. After release, `busy` falls within a bounded time, and `clk_out` then has the period of the boot source.
- R2: Code c (0..4) selects `src_clk[c]`. After an accepted switch, `rdata[2:0]` equals c, and the period of `clk_out` equals the period of `src_clk[c]`.
- R3: A select write of code 5, 6 or 7 while idle leaves `rdata[2:0]` and the output source unchanged, sets `err`, and never raises `busy`.
- R4: A select write of the code already in use, while idle, completes at once: `busy` stays low.
- R5: An accepted switch to a different code reads `busy` = 1 from the cycle after the write until the new source is confirmed. The old source is confirmed off before the new one is enabled, so at most one source is ever engaged.
- R6: No high or low phase of `clk_out` is shorter than the shorter half-period of the old and new sources involved.
- R7: A select write changes only `rdata[2:0]`. An `aux_we` write changes only `rdata[7:3]`.
- R8: A pinned instance always reads code `PINNED_CODE` and runs from that source. Each select write to it is refused and sets `err`.
- R9: A select write in any cycle where `busy` reads 1 is refused: it sets `err`, and the handover goes on to its original target. A write held until `busy` first reads 0 is accepted on the next edge.
- R10: An accepted select write, including a same-code write, clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock for the register port and the handshake |
| rst | input | 1 | Synchronous active-high reset (control domain) |
| src_clk | input | N_SRC | Candidate source clocks, index = source code |
| sel_we | input | 1 | Write strobe for the select field |
| aux_we | input | 1 | Write strobe for the spare control field |
| wdata | input | SEL_W+AUX_W | Write data: [2:0] select code, [7:3] spare field |
| rdata | output | SEL_W+AUX_W | Readback: [2:0] select code, [7:3] spare field |
| busy | output | 1 | High while a handover is in progress |
| err | output | 1 | Sticky flag for a refused select write |
| clk_out | output | 1 | Selected, glitch-free output clock |

## Verification
A select write and the completion of a handover can fall in the same control cycle. The bench provokes this by holding a valid select write asserted for the whole of a handover. Every cycle in which busy reads high must refuse the write and set the error flag. The edge right after busy first reads low must accept it, which re-raises busy, clears the error flag and loads the new code. All 25 source-to-source pairs are swept as well, with every output phase timed against the shorter half-period of the pair.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int unsigned CS_N_SRC   = 5;
    localparam int unsigned CS_SEL_W   = 3;
    localparam int unsigned CS_AUX_W   = 5;
    localparam int unsigned CS_SYNC    = 2;
    localparam int unsigned CS_BOOT    = 1;
    localparam int unsigned CS_PIN_SRC = 4;

    // handover sequencer states
    typedef enum logic [1:0] {
        HS_BOOT   = 2'd0,   // waiting for the boot source to be confirmed
        HS_IDLE   = 2'd1,   // steady, select writes accepted
        HS_DRAIN  = 2'd2,   // old source released, awaiting confirmation
        HS_ENGAGE = 2'd3    // new source requested, awaiting confirmation
    } hs_state_e;

    // a source code is legal when it names an existing input
    function automatic bit code_ok(input int unsigned code, input int unsigned n_src);
        return code < n_src;
    endfunction

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_lane.sv
module clksel_lane #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,        // control domain
    input  logic src_clk,    // this lane's source
    input  logic en_req,     // control-domain enable request
    output logic ack,        // gate state seen in control domain
    output logic clk_gated
);
    logic en_src;
    logic gate_q;

    // request into the source domain
    clksel_sync #(.STAGES(SYNC_STAGES)) u_fwd (
        .clk (src_clk),
        .d   (en_req),
        .q   (en_src)
    );

    // gate only changes while the source is low
    always_ff @(negedge src_clk) begin
        gate_q <= en_src;
    end

    assign clk_gated = src_clk & gate_q;

    // confirmation back to the control domain
    clksel_sync #(.STAGES(SYNC_STAGES)) u_back (
        .clk (clk),
        .d   (gate_q),
        .q   (ack)
    );
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int unsigned N_SRC       = CS_N_SRC,
    parameter int unsigned SEL_W       = CS_SEL_W,
    parameter int unsigned AUX_W       = CS_AUX_W,
    parameter int unsigned BOOT_CODE   = CS_BOOT,
    parameter bit          PINNED      = 1'b0,
    parameter int unsigned PINNED_CODE = CS_PIN_SRC,
    localparam int unsigned CTRL_W     = SEL_W + AUX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic              aux_we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [N_SRC-1:0]  ack,
    output logic [N_SRC-1:0]  en_req,
    output logic [CTRL_W-1:0] rdata,
    output logic              busy,
    output logic              err
);
    localparam int unsigned START_CODE = PINNED ? PINNED_CODE : BOOT_CODE;
    localparam logic [N_SRC-1:0] START_OH = N_SRC'(1) << START_CODE;

    hs_state_e          state_q, state_d;
    logic [SEL_W-1:0]   sel_q, sel_d;
    logic [SEL_W-1:0]   cur_q, cur_d;
    logic [SEL_W-1:0]   tgt_q, tgt_d;
    logic [AUX_W-1:0]   aux_q, aux_d;
    logic [N_SRC-1:0]   en_q, en_d;
    logic               err_q, err_d;

    logic [SEL_W-1:0]   wr_code;
    logic [AUX_W-1:0]   wr_aux;
    logic               wr_legal;
    logic [N_SRC-1:0]   cur_oh, tgt_oh;
    logic               cur_on, tgt_on;

    assign wr_code  = wdata[SEL_W-1:0];
    assign wr_aux   = wdata[CTRL_W-1:SEL_W];
    assign wr_legal = code_ok(32'(wr_code), N_SRC) && !PINNED;

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            cur_oh[i] = (cur_q == SEL_W'(i));
            tgt_oh[i] = (tgt_q == SEL_W'(i));
        end
    end

    assign cur_on = |(ack & cur_oh);
    assign tgt_on = |(ack & tgt_oh);

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        cur_d   = cur_q;
        tgt_d   = tgt_q;
        en_d    = en_q;
        err_d   = err_q;
        aux_d   = aux_we ? wr_aux : aux_q;
        unique case (state_q)
            HS_BOOT: begin
                if (sel_we) err_d = 1'b1;
                if (cur_on) state_d = HS_IDLE;
            end
            HS_IDLE: begin
                if (sel_we) begin
                    if (!wr_legal) begin
                        err_d = 1'b1;
                    end else begin
                        err_d = 1'b0;
                        if (wr_code != cur_q) begin
                            sel_d   = wr_code;
                            tgt_d   = wr_code;
                            en_d    = en_q & ~cur_oh;
                            state_d = HS_DRAIN;
                        end
                    end
                end
            end
            HS_DRAIN: begin
                if (sel_we) err_d = 1'b1;
                if (!cur_on) begin
                    en_d    = en_q | tgt_oh;
                    state_d = HS_ENGAGE;
                end
            end
            HS_ENGAGE: begin
                if (sel_we) err_d = 1'b1;
                if (tgt_on) begin
                    cur_d   = tgt_q;
                    state_d = HS_IDLE;
                end
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_BOOT;
            sel_q   <= SEL_W'(START_CODE);
            cur_q   <= SEL_W'(START_CODE);
            tgt_q   <= SEL_W'(START_CODE);
            aux_q   <= '0;
            en_q    <= START_OH;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            cur_q   <= cur_d;
            tgt_q   <= tgt_d;
            aux_q   <= aux_d;
            en_q    <= en_d;
            err_q   <= err_d;
        end
    end

    assign en_req = en_q;
    assign rdata  = {aux_q, sel_q};
    assign busy   = (state_q != HS_IDLE);
    assign err    = err_q;
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
    import clksel_pkg::*;
#(
    parameter int unsigned N_SRC       = CS_N_SRC,
    parameter int unsigned SEL_W       = CS_SEL_W,
    parameter int unsigned AUX_W       = CS_AUX_W,
    parameter int unsigned SYNC_STAGES = CS_SYNC,
    parameter int unsigned BOOT_CODE   = CS_BOOT,
    parameter bit          PINNED      = 1'b0,
    parameter int unsigned PINNED_CODE = CS_PIN_SRC,
    localparam int unsigned CTRL_W     = SEL_W + AUX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_clk,
    input  logic              sel_we,
    input  logic              aux_we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output logic              busy,
    output logic              err,
    output logic              clk_out
);
    logic [N_SRC-1:0] en_vec;
    logic [N_SRC-1:0] ack_vec;
    logic [N_SRC-1:0] gated_vec;

    clksel_ctrl #(
        .N_SRC       (N_SRC),
        .SEL_W       (SEL_W),
        .AUX_W       (AUX_W),
        .BOOT_CODE   (BOOT_CODE),
        .PINNED      (PINNED),
        .PINNED_CODE (PINNED_CODE)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .sel_we (sel_we),
        .aux_we (aux_we),
        .wdata  (wdata),
        .ack    (ack_vec),
        .en_req (en_vec),
        .rdata  (rdata),
        .busy   (busy),
        .err    (err)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_lane
        clksel_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk       (clk),
            .src_clk   (src_clk[g]),
            .en_req    (en_vec[g]),
            .ack       (ack_vec[g]),
            .clk_gated (gated_vec[g])
        );
    end

    // at most one lane is ever open, so an OR merges them
    assign clk_out = |gated_vec;
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk #(
    parameter int unsigned N_SRC       = 5,
    parameter int unsigned SEL_W       = 3,
    parameter int unsigned AUX_W       = 5,
    parameter bit          PINNED      = 1'b0,
    parameter int unsigned PINNED_CODE = 4,
    localparam int unsigned CTRL_W     = SEL_W + AUX_W
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_we,
    input logic              aux_we,
    input logic [CTRL_W-1:0] wdata,
    input logic [CTRL_W-1:0] rdata,
    input logic              busy,
    input logic              err,
    input logic [N_SRC-1:0]  ack_vec
);
    // R5: never two sources confirmed engaged at once
    a_r5_single_engaged: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_vec));

    // R3: illegal code while idle keeps the selection and flags an error
    a_r3_illegal_kept: assert property (@(posedge clk) disable iff (rst)
        (sel_we && !busy && int'(wdata[SEL_W-1:0]) >= int'(N_SRC))
        |=> (err && !busy && $stable(rdata[SEL_W-1:0])));

    // R4: rewriting the current code never starts a handover
    a_r4_same_code_quiet: assert property (@(posedge clk) disable iff (rst)
        (sel_we && !busy && !PINNED && wdata[SEL_W-1:0] == rdata[SEL_W-1:0])
        |=> (!busy && !err));

    // R7: the spare field moves only on its own strobe
    a_r7_aux_isolated: assert property (@(posedge clk) disable iff (rst)
        !aux_we |=> $stable(rdata[CTRL_W-1:SEL_W]));

    // R9: a select write during a handover is refused
    a_r9_busy_refuse: assert property (@(posedge clk) disable iff (rst)
        (sel_we && busy) |=> (err && $stable(rdata[SEL_W-1:0])));

    // R8: a pinned instance never reports another code
    a_r8_pinned_code: assert property (@(posedge clk) disable iff (rst)
        PINNED |-> (rdata[SEL_W-1:0] == SEL_W'(PINNED_CODE)));
endmodule

bind clk_src_switch clk_src_switch_chk #(
    .N_SRC       (N_SRC),
    .SEL_W       (SEL_W),
    .AUX_W       (AUX_W),
    .PINNED      (PINNED),
    .PINNED_CODE (PINNED_CODE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_we  (sel_we),
    .aux_we  (aux_we),
    .wdata   (wdata),
    .rdata   (rdata),
    .busy    (busy),
    .err     (err),
    .ack_vec (ack_vec)
);

// File: tb/clk_src_switch_bench.sv
`timescale 1ns/1ps
module clk_src_switch_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0, s4 = 1'b0;
    logic [4:0] sclk;

    logic       sel_we = 1'b0, aux_we = 1'b0;
    logic [7:0] wdata  = '0;
    logic [7:0] rdata;
    logic       busy, err, clk_out;

    logic       p_sel_we = 1'b0;
    logic [7:0] p_wdata  = '0;
    logic [7:0] p_rdata;
    logic       p_busy, p_err, p_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;
    always #97 s0 = ~s0;
    always #13 s1 = ~s1;
    always #7  s2 = ~s2;
    always #9  s3 = ~s3;
    always #5  s4 = ~s4;
    assign sclk = {s4, s3, s2, s1, s0};

    clk_src_switch u_clk_src_switch (
        .clk(clk), .rst(rst), .src_clk(sclk), .sel_we(sel_we), .aux_we(aux_we),
        .wdata(wdata), .rdata(rdata), .busy(busy), .err(err), .clk_out(clk_out)
    );

    clk_src_switch #(.PINNED(1'b1)) u_pinned (
        .clk(clk), .rst(rst), .src_clk(sclk), .sel_we(p_sel_we), .aux_we(1'b0),
        .wdata(p_wdata), .rdata(p_rdata), .busy(p_busy), .err(p_err), .clk_out(p_out)
    );

    function automatic int hp(input int c);
        case (c)
            0: return 97;
            1: return 13;
            2: return 7;
            3: return 9;
            default: return 5;
        endcase
    endfunction

    // phase monitor for R6
    real last_t = 0.0;
    real min_ph = 1000.0;
    int  runts  = 0;
    bit  mon_en = 1'b0;
    always @(clk_out) begin
        if (mon_en && ($realtime - last_t) < (min_ph - 0.001)) runts++;
        last_t = $realtime;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic period_ps(output int ps);
        realtime t0, t1;
        @(posedge clk_out); t0 = $realtime;
        @(posedge clk_out); t1 = $realtime;
        ps = int'((t1 - t0) * 1000.0);
    endtask

    task automatic pin_period_ps(output int ps);
        realtime t0, t1;
        @(posedge p_out); t0 = $realtime;
        @(posedge p_out); t1 = $realtime;
        ps = int'((t1 - t0) * 1000.0);
    endtask

    int         cur = 1;
    logic [4:0] aux_exp = '0;

    task automatic do_switch(input int to);
        int ps;
        min_ph = real'((hp(cur) < hp(to)) ? hp(cur) : hp(to));
        runts  = 0;
        @(negedge clk);
        sel_we = 1'b1;
        wdata  = {~aux_exp, 3'(to)};
        @(negedge clk);
        sel_we = 1'b0;
        if (to != cur) chk(busy == 1'b1, "R5 busy after switch write", int'(busy), 1);
        else           chk(busy == 1'b0, "R4 same code no busy", int'(busy), 0);
        wait_idle();
        chk(rdata[2:0] == 3'(to), "R2 code readback", int'(rdata[2:0]), to);
        chk(err == 1'b0, "R10 err cleared", int'(err), 0);
        chk(rdata[7:3] == aux_exp, "R7 spare kept on select write", int'(rdata[7:3]), int'(aux_exp));
        period_ps(ps);
        chk(ps == 2000 * hp(to), "R2 output period", ps, 2000 * hp(to));
        chk(runts == 0, "R6 no runt phase", runts, 0);
        cur    = to;
        min_ph = real'(hp(to));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ps;
        // R1 reset state
        repeat (5) @(negedge clk);
        chk(rdata[2:0] == 3'd1, "R1 reset code", int'(rdata[2:0]), 1);
        chk(err == 1'b0, "R1 reset err", int'(err), 0);
        chk(rdata[7:3] == 5'd0, "R1 reset spare", int'(rdata[7:3]), 0);
        chk(p_rdata[2:0] == 3'd4, "R8 pinned reset code", int'(p_rdata[2:0]), 4);
        rst = 1'b0;
        @(negedge clk);
        wait_idle();
        chk(busy == 1'b0, "R1 busy falls after reset", int'(busy), 0);
        period_ps(ps);
        chk(ps == 2000 * hp(1), "R1 boot period", ps, 2000 * hp(1));
        min_ph = real'(hp(1));
        mon_en = 1'b1;

        // R7 spare-field write leaves selection alone
        @(negedge clk);
        aux_we  = 1'b1;
        wdata   = 8'b10110_111;
        aux_exp = 5'b10110;
        @(negedge clk);
        aux_we = 1'b0;
        chk(rdata[7:3] == aux_exp, "R7 spare write", int'(rdata[7:3]), int'(aux_exp));
        chk(rdata[2:0] == 3'd1 && !busy && !err, "R7 select untouched by spare write",
            int'(rdata[2:0]), 1);

        // R2 R5 R6 full pair sweep
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                if (cur != a) do_switch(a);
                do_switch(b);
            end
        end

        // R3 illegal codes from two different sources
        for (int k = 0; k < 2; k++) begin
            do_switch(k == 0 ? 2 : 0);
            for (int c = 5; c < 8; c++) begin
                @(negedge clk);
                sel_we = 1'b1;
                wdata  = {aux_exp, 3'(c)};
                @(negedge clk);
                sel_we = 1'b0;
                chk(err == 1'b1, "R3 illegal sets err", int'(err), 1);
                chk(busy == 1'b0, "R3 illegal no busy", int'(busy), 0);
                chk(rdata[2:0] == 3'(cur), "R3 illegal keeps code", int'(rdata[2:0]), cur);
            end
            period_ps(ps);
            chk(ps == 2000 * hp(cur), "R3 output unchanged", ps, 2000 * hp(cur));
            // R4 R10 same-code write clears the flag, busy stays low
            @(negedge clk);
            sel_we = 1'b1;
            wdata  = {aux_exp, 3'(cur)};
            @(negedge clk);
            sel_we = 1'b0;
            chk(err == 1'b0, "R10 same code clears err", int'(err), 0);
            begin
                int hi = 0;
                repeat (20) begin
                    if (busy) hi++;
                    @(negedge clk);
                end
                chk(hi == 0, "R4 busy never rose", hi, 0);
            end
        end

        // R9 write during handover refused, target unchanged
        do_switch(1);
        @(negedge clk);
        sel_we = 1'b1;
        wdata  = {aux_exp, 3'd3};
        @(negedge clk);
        wdata  = {aux_exp, 3'd2};
        @(negedge clk);
        sel_we = 1'b0;
        chk(err == 1'b1, "R9 busy write sets err", int'(err), 1);
        chk(rdata[2:0] == 3'd3, "R9 busy write keeps target", int'(rdata[2:0]), 3);
        wait_idle();
        period_ps(ps);
        chk(ps == 2000 * hp(3), "R9 original target reached", ps, 2000 * hp(3));
        cur    = 3;
        min_ph = real'(hp(3));

        // R9 write held across completion: first edge with busy low accepts
        @(negedge clk);
        sel_we = 1'b1;
        wdata  = {aux_exp, 3'd0};
        min_ph = real'(hp(4));
        runts  = 0;
        @(negedge clk);
        // the held write is now accepted, switching 3 -> 0; hold a different code
        wdata  = {aux_exp, 3'd4};
        begin
            int n = 0;
            while (busy && n < 5000) begin
                @(negedge clk);
                n++;
            end
        end
        chk(err == 1'b1, "R9 held write refused while busy", int'(err), 1);
        @(negedge clk);
        sel_we = 1'b0;
        chk(busy == 1'b1, "R9 held write accepted at completion", int'(busy), 1);
        chk(err == 1'b0, "R9 accepted write clears err", int'(err), 0);
        chk(rdata[2:0] == 3'd4, "R9 accepted code", int'(rdata[2:0]), 4);
        wait_idle();
        period_ps(ps);
        chk(ps == 2000 * hp(4), "R9 final source", ps, 2000 * hp(4));
        cur = 4;

        // R8 pinned instance
        begin
            int n = 0;
            while (p_busy && n < 5000) begin
                @(negedge clk);
                n++;
            end
        end
        pin_period_ps(ps);
        chk(ps == 2000 * hp(4), "R8 pinned period", ps, 2000 * hp(4));
        @(negedge clk);
        p_sel_we = 1'b1;
        p_wdata  = 8'd2;
        @(negedge clk);
        p_sel_we = 1'b0;
        chk(p_err == 1'b1, "R8 pinned write refused", int'(p_err), 1);
        chk(p_rdata[2:0] == 3'd4, "R8 pinned code kept", int'(p_rdata[2:0]), 4);
        chk(p_busy == 1'b0, "R8 pinned no busy", int'(p_busy), 0);
        pin_period_ps(ps);
        chk(ps == 2000 * hp(4), "R8 pinned source kept", ps, 2000 * hp(4));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule